// File: doc/BRIEF.md
# Configurable Symmetric FIR Filter

This block is a finite impulse response filter built from a small array of multiply-add cells (eight in the default build). Each input sample is a 12-bit two's-complement value marked by a valid strobe; each coefficient is a 14-bit two's-complement value. Results are produced at full 32-bit precision, one result per input sample. The filter can run with independent coefficients (arbitrary phase) or as a linear-phase filter whose impulse response is mirrored about its centre. In mirrored mode each cell first adds a pair of delayed samples and then multiplies, so the same cells cover twice the taps. When samples arrive at a half or a quarter of the clock rate, the cells are reused over the spare cycles, which doubles or quadruples the tap count again.

Coefficients are held in two banks. The host writes a new set into the bank not in use (the shadow bank), then raises a swap request. The swap is applied only where a new sample starts, so every result is computed with one complete coefficient set and never with a mixture of two.

A two-state controller sequences the work. In state IDLE the block waits for a sample. The phase-0 partial sum is formed in the cycle the sample arrives. At full rate that partial sum is the result, and the controller stays in IDLE (transition IDLE->IDLE). At half or quarter rate the controller moves to BUSY (transition IDLE->BUSY) and accumulates one further partial sum per cycle. After the last phase it returns to IDLE (transition BUSY->IDLE); until then it remains in BUSY (transition BUSY->BUSY).

Top module: `fir_sym_top`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, bank_active is 0, both coefficient banks hold zeros and the sample history holds zeros, so the first outputs after reset are 0.
- R2: With sym_mode 0 or 3 (arbitrary phase), let F be the rate factor of R5 and U = 8*F. Each result is y = sum over k < U of c[k]*x[n-k], where c[k] is the coefficient at write address k and x[n] is the newest sample.
- R3: With sym_mode 1 (even length), the filter has T = 2U taps with h[k] = h[T-1-k] = c[k] for k < U.
- R4: With sym_mode 2 (odd length), the filter has T = 2U-1 taps with h[k] = h[T-1-k] = c[k] for k < U. The centre tap c[U-1] is applied once.
- R5: rate_mode 0, 1 and 2 (3 behaves as 2) give rate factors F = 1, 2 and 4. Samples must be at least F cycles apart. For each sample, out_valid is high for exactly one cycle, following the F-th rising edge, counting the edge that takes in_valid as the first.
- R6: The result is exact in 32 bits even with all inputs at their most negative values in the 64-tap mode. out_data holds its value while out_valid is low.
- R7: Writes with coef_we go to the bank not in use. They leave results and bank_active unchanged until a swap.
- R8: A swap_req pulse is held pending until the next sample; a pulse in the same cycle as in_valid counts for that sample. bank_active toggles at the rising edge that takes that sample, and the sample is filtered entirely with the new bank.
- R9: sym_mode and rate_mode are taken in the cycle in_valid is high and kept for that sample. Changes on those inputs during the remaining phases have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a new input sample |
| in_data | input | 12 | Input sample, two's complement |
| sym_mode | input | 2 | 0/3 arbitrary, 1 even length, 2 odd length |
| rate_mode | input | 2 | 0 full, 1 half, 2/3 quarter rate |
| coef_we | input | 1 | Write strobe for the shadow bank |
| coef_addr | input | 5 | Unique coefficient index |
| coef_data | input | 14 | Coefficient value, two's complement |
| swap_req | input | 1 | Request to exchange the banks at the next sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 32 | Filter result, two's complement |
| bank_active | output | 1 | Bank currently in use |

## Verification
An impulse followed by a short stream of varied samples is passed through every combination of mirroring and rate. This shows that each tap gets its own coefficient and that the partner index changes between even and odd length, with the centre tap applied once for odd length. Mode changes between samples, while the history carries on, test that the delay line is shared correctly across modes. Scrambled mode inputs on the idle cycles of each sample show whether modes are latched. Shadow writes, a swap requested on its own and a swap requested in the same cycle as a sample show whether writes or swaps ever reach a result early. All-negative extremes check the full 32-bit result.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;
    localparam logic [1:0] SYM_EVEN = 2'd1;
    localparam logic [1:0] SYM_ODD  = 2'd2;

    typedef enum logic {ST_IDLE, ST_BUSY} fsm_e;

    function automatic int rate_mult(input logic [1:0] r);
        case (r)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int NCELL = 8,
    parameter int MAXU  = 32,
    parameter int AW    = 5,
    parameter int CW    = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic                 swap_req,
    input  logic                 start,
    input  logic [1:0]           rd_phase,
    output logic                 bank_q,
    output logic signed [CW-1:0] coef [NCELL]
);
    logic signed [CW-1:0] mem [2][MAXU];
    logic pend_q, take, eff;

    assign take = start & (pend_q | swap_req);
    assign eff  = bank_q ^ take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            pend_q <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < MAXU; i++)
                    mem[b][i] <= '0;
        end else begin
            bank_q <= eff;
            pend_q <= take ? 1'b0 : (pend_q | swap_req);
            if (we)
                mem[~bank_q][waddr] <= wdata;
        end
    end

    always_comb begin
        for (int j = 0; j < NCELL; j++)
            coef[j] = mem[eff][AW'(j + NCELL * int'(rd_phase))];
    end
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
    parameter int DEPTH = 64,
    parameter int DW    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] view [DEPTH]
);
    logic signed [DW-1:0] line [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++)
                line[k] <= '0;
        end else if (shift) begin
            line[0] <= din;
            for (int k = 1; k < DEPTH; k++)
                line[k] <= line[k-1];
        end
    end

    always_comb begin
        view[0] = shift ? din : line[0];
        for (int k = 1; k < DEPTH; k++)
            view[k] = shift ? line[k-1] : line[k];
    end
endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
    parameter int DW   = 12,
    parameter int CW   = 14,
    parameter int ACCW = 32
) (
    input  logic signed [DW-1:0]   a,
    input  logic signed [DW-1:0]   b,
    input  logic                   use_b,
    input  logic signed [CW-1:0]   coef,
    output logic signed [ACCW-1:0] prod
);
    logic signed [DW:0]    pre;
    logic signed [DW+CW:0] full;

    always_comb begin
        pre  = (DW+1)'(a) + (use_b ? (DW+1)'(b) : '0);
        full = pre * coef;
        prod = ACCW'(full);
    end
endmodule

// File: rtl/fir_sym_top.sv
module fir_sym_top
    import fir_sym_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int DW    = 12,
    parameter int CW    = 14,
    parameter int ACCW  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_data,
    input  logic [1:0]             sym_mode,
    input  logic [1:0]             rate_mode,
    input  logic                   coef_we,
    input  logic [$clog2(NCELL*4)-1:0] coef_addr,
    input  logic signed [CW-1:0]   coef_data,
    input  logic                   swap_req,
    output logic                   out_valid,
    output logic signed [ACCW-1:0] out_data,
    output logic                   bank_active
);
    localparam int MAXU = NCELL * 4;
    localparam int MAXT = 2 * MAXU;
    localparam int AW   = $clog2(MAXU);
    localparam int IW   = $clog2(MAXT);

    fsm_e state, nxt;
    logic [1:0] phase_q, sym_q, rate_q;
    logic [1:0] cur_sym, cur_rate, cur_phase;
    int         rmul;
    logic       active, last;
    logic signed [ACCW-1:0] acc_q, acc_next, sum;
    logic signed [DW-1:0]   view [MAXT];
    logic signed [CW-1:0]   coefs [NCELL];
    logic signed [ACCW-1:0] prod [NCELL];

    always_comb begin
        cur_sym   = in_valid ? sym_mode  : sym_q;
        cur_rate  = in_valid ? rate_mode : rate_q;
        cur_phase = (state == ST_IDLE) ? 2'd0 : phase_q;
        rmul      = rate_mult(cur_rate);
        active    = in_valid | (state == ST_BUSY);
        last      = (cur_phase == 2'(rmul - 1));
    end

    fir_coef_bank #(.NCELL(NCELL), .MAXU(MAXU), .AW(AW), .CW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr),
        .wdata(coef_data), .swap_req(swap_req), .start(in_valid),
        .rd_phase(cur_phase), .bank_q(bank_active), .coef(coefs)
    );

    fir_delay_line #(.DEPTH(MAXT), .DW(DW)) u_line (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_data), .view(view)
    );

    for (genvar j = 0; j < NCELL; j++) begin : g_cell
        logic [IW-1:0] ia, ib;
        logic          useb;
        always_comb begin
            int u, nu, nt;
            nu = rmul * NCELL;
            if (cur_sym == SYM_EVEN)     nt = 2 * nu;
            else if (cur_sym == SYM_ODD) nt = 2 * nu - 1;
            else                         nt = nu;
            u    = int'(cur_phase) * NCELL + j;
            ia   = IW'(u);
            ib   = IW'(nt - 1 - u);
            useb = (cur_sym == SYM_EVEN) || ((cur_sym == SYM_ODD) && (u != nu - 1));
        end
        fir_mac_cell #(.DW(DW), .CW(CW), .ACCW(ACCW)) u_cell (
            .a(view[ia]), .b(view[ib]), .use_b(useb),
            .coef(coefs[j]), .prod(prod[j])
        );
    end

    always_comb begin
        sum = '0;
        for (int j = 0; j < NCELL; j++)
            sum = sum + prod[j];
        acc_next = ((cur_phase == 2'd0) ? '0 : acc_q) + sum;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (in_valid && rmul > 1) nxt = ST_BUSY;
            ST_BUSY: if (last)                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase_q <= 2'd0;
            sym_q   <= 2'd0;
            rate_q  <= 2'd0;
        end else begin
            state <= nxt;
            if (in_valid) begin
                sym_q   <= sym_mode;
                rate_q  <= rate_mode;
                phase_q <= 2'd1;
            end else if (state == ST_BUSY) begin
                phase_q <= phase_q + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            acc_q     <= '0;
        end else begin
            out_valid <= active && last;
            if (active) acc_q <= acc_next;
            if (active && last) out_data <= acc_next;
        end
    end
endmodule

// File: rtl/fir_sym_chk.sv
module fir_sym_chk #(
    parameter int ACCW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      rate_mode,
    input logic            swap_req,
    input logic            out_valid,
    input logic [ACCW-1:0] out_data,
    input logic            bank_active
);
    a_r5_full_rate_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rate_mode == 2'd0 |=> out_valid);

    a_r5_half_rate_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rate_mode == 2'd1 |=> !out_valid ##1 out_valid);

    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> $stable(out_data) || out_valid);

    a_r8_swap_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && swap_req |=> bank_active != $past(bank_active));

    a_r8_bank_moves_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_active) |-> $past(in_valid));
endmodule

bind fir_sym_top fir_sym_chk #(.ACCW(ACCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rate_mode(rate_mode),
    .swap_req(swap_req), .out_valid(out_valid), .out_data(out_data),
    .bank_active(bank_active)
);

// File: tb/fir_sym_top_test.sv
`timescale 1ns/1ps
module fir_sym_top_test;
    logic clk = 0, rst_n = 0;
    logic in_valid = 0, coef_we = 0, swap_req = 0;
    logic signed [11:0] in_data = '0;
    logic [1:0] sym_mode = 0, rate_mode = 0;
    logic [4:0] coef_addr = '0;
    logic signed [13:0] coef_data = '0;
    logic out_valid, bank_active;
    logic signed [31:0] out_data;

    fir_sym_top uut (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    int exp_q[$];
    string tag_q[$];
    int hist [64];
    int cf [2][32];
    int mbank = 0, mpend = 0, last_exp = 0;
    logic [1:0] cur_sym = 0, cur_rate = 0;

    function automatic int fac(input logic [1:0] r);
        return (r == 0) ? 1 : (r == 1) ? 2 : 4;
    endfunction

    function automatic int model(input logic [1:0] s, input logic [1:0] r);
        longint y = 0;
        int u = 8 * fac(r), t, idx;
        t = (s == 1) ? 2*u : (s == 2) ? 2*u - 1 : u;
        for (int k = 0; k < t; k++) begin
            idx = (k < u) ? k : t - 1 - k;
            y += longint'(cf[mbank][idx]) * hist[k];
        end
        return int'(y);
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        coef_we = 1; coef_addr = 5'(a); coef_data = 14'(d);
        cf[1-mbank][a] = d;
        @(negedge clk);
        coef_we = 0;
    endtask

    task automatic req_swap();
        @(negedge clk);
        swap_req = 1; mpend = 1;
        @(negedge clk);
        swap_req = 0;
    endtask

    task automatic send(input int x, input bit sw, input string tag);
        int r;
        @(negedge clk);
        in_valid = 1; in_data = 12'(x);
        sym_mode = cur_sym; rate_mode = cur_rate; swap_req = sw;
        if (sw) mpend = 1;
        if (mpend) begin mbank = 1 - mbank; mpend = 0; end
        for (int k = 63; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        exp_q.push_back(model(cur_sym, cur_rate));
        tag_q.push_back(tag);
        r = fac(cur_rate);
        @(negedge clk);
        in_valid = 0; swap_req = 0;
        sym_mode = ~cur_sym; rate_mode = ~cur_rate;  // R9 scramble
        repeat (r - 1) @(negedge clk);
    endtask

    task automatic stream(input logic [1:0] s, input logic [1:0] r, input string tag);
        cur_sym = s; cur_rate = r;
        send(1000, 0, tag);
        for (int i = 0; i < 70; i++) send(((i * 523) % 4000) - 2000, 0, tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected out_valid actual=1 expected=0");
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), out_data, last_exp);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int k = 0; k < 64; k++) hist[k] = 0;
        for (int b = 0; b < 2; b++) for (int i = 0; i < 32; i++) cf[b][i] = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 out_data", out_data, 0);
        check("R1 bank_active", bank_active, 0);
        rst_n = 1;
        cur_sym = 1; cur_rate = 0;
        for (int i = 0; i < 3; i++) send(700 - i, 0, "R1 zero coefficients");
        // R7: load shadow, result still from zero bank
        for (int i = 0; i < 32; i++) wr(i, (i * 371) % 8000 - 4000);
        check("R7 bank unchanged by writes", bank_active, 0);
        send(-1500, 0, "R7 shadow write invisible");
        req_swap();
        repeat (3) @(negedge clk);
        check("R8 swap pending holds bank", bank_active, 0);
        stream(0, 0, "R2 arbitrary full");
        check("R8 bank after swap", bank_active, 1);
        stream(0, 1, "R2 arbitrary half");
        stream(3, 2, "R2 arbitrary quarter");
        stream(1, 1, "R3 even half");
        stream(1, 3, "R3 even quarter");
        stream(2, 2, "R4 odd quarter");
        stream(2, 0, "R4 odd full");
        stream(1, 0, "R5 even full");
        // R8: new set into bank 0, swap in the same cycle as a sample
        for (int i = 0; i < 32; i++) wr(i, 2000 - i * 113);
        cur_sym = 2; cur_rate = 1;
        send(1234, 1, "R8 swap with sample");
        check("R8 bank toggled", bank_active, 0);
        for (int i = 0; i < 20; i++) send(i * 97 - 900, 0, "R8 new bank stream");
        // R6: extremes in 64-tap mode
        for (int i = 0; i < 32; i++) wr(i, -8192);
        req_swap();
        cur_sym = 1; cur_rate = 2;
        for (int i = 0; i < 66; i++) send(-2048, 0, "R6 extreme");
        repeat (10) @(negedge clk);
        check("R6 hold out_data", out_data, last_exp);
        check("R6 extreme value", last_exp, 1 << 30);
        check("R5 all results delivered", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule